// File: doc/BRIEF.md
# RS-485 Drive-Direction and Station-Address Controller

This block sits next to a UART core on a multidrop RS-485 bus and handles the two jobs that the plain serial shifters do not. On the transmit side it turns the line driver on while the transmitter has anything to send. After the last stop bit it keeps the driver on for a programmed number of bit times, then turns it off. The driver-enable level can be inverted, and it can be carried on either the RTS or the DTR modem pin. When automatic control is off, both modem pins simply carry their ordinary modem-control levels.

On the receive side every character arrives with a ninth bit in the parity position. In multidrop mode a set ninth bit marks the character as a station address: the character is flagged and a one-cycle address interrupt is raised. In automatic address mode the block opens its receive gate only after an address equal to the programmed station address. While the gate is closed it discards data characters. A software receiver-off bit overrides everything and discards all characters.

Top module: `rs485_link_ctrl`

## Requirements
- R1: After reset, `rx_out_valid` and `addr_irq` are 0 and the receive gate is closed, so `rx_enabled` is 0 whenever automatic address mode is on.
- R2: With `dir_auto` = 0, `rts_pin` equals `mc_rts` and `dtr_pin` equals `mc_dtr` at all times, whatever the transmitter does.
- R3: With `dir_auto` = 1, `dir_sel` = 0 selects RTS and `dir_sel` = 1 selects DTR. The non-selected pin keeps its modem-control level.
- R4: The direction pin is active from the clock after `tx_active` is first sampled high. With `dir_pol` = 0 the active level is 0 and the idle level is 1; `dir_pol` = 1 swaps the two levels.
- R5: Once `tx_active` is sampled low, the pin stays active until `dir_hold` bit ticks have been counted on clocks with `tx_active` low. It returns to idle at the next clock with `tx_active` still low after that count. A hold of 0 releases it at the first low clock.
- R6: If `tx_active` rises again before the hold expires, the pin stays active without a gap and the hold count restarts from the full `dir_hold` value.
- R7: With `multidrop` = 0, the ninth bit is ignored: every accepted character leaves with `rx_out_addr` = 0 and no `addr_irq`.
- R8: With `multidrop` = 1, an accepted character whose ninth bit is 1 leaves with `rx_out_addr` = 1, and `addr_irq` pulses in the same cycle. An accepted character is output one clock after `rx_valid` is sampled.
- R9: With `rx_off` = 1, no character is output and no interrupt is raised.
- R10: In automatic address mode (`multidrop` = 1 and `auto_addr` = 1), an address equal to `station_addr` opens the gate and is output. Data characters (ninth bit 0) are output only while the gate is open.
- R11: In automatic address mode, an address that differs from `station_addr` closes the gate and is discarded without an interrupt. Data characters that follow it are discarded.
- R12: `rx_enabled` equals 1 exactly when `rx_off` = 0 and either automatic address mode is off or the gate is open.
- R13: Any clock spent outside automatic address mode closes the gate, so automatic address mode always starts with the gate closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_auto | input | 1 | Automatic direction control on |
| dir_sel | input | 1 | 0: direction on RTS, 1: direction on DTR |
| dir_pol | input | 1 | 0: active-low driver enable, 1: active-high |
| dir_hold | input | HOLD_W | Bit ticks to hold after transmission ends |
| mc_rts | input | 1 | Ordinary RTS level from modem control |
| mc_dtr | input | 1 | Ordinary DTR level from modem control |
| tx_active | input | 1 | Transmitter holds data (holding or shift register not empty) |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| rts_pin | output | 1 | RTS pin level |
| dtr_pin | output | 1 | DTR pin level |
| multidrop | input | 1 | Ninth bit marks addresses |
| auto_addr | input | 1 | Hardware address matching gates the receiver |
| rx_off | input | 1 | Software receiver off |
| station_addr | input | DATA_W | Address to match |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | DATA_W | Received character |
| rx_ninth | input | 1 | Ninth (parity-position) bit of the character |
| rx_out_valid | output | 1 | Accepted character strobe |
| rx_out_data | output | DATA_W | Accepted character |
| rx_out_addr | output | 1 | Accepted character is an address |
| addr_irq | output | 1 | One-cycle address-detect interrupt |
| rx_enabled | output | 1 | Receiver currently accepts data characters |

## Verification
The bench uses the default widths: 8-bit characters and an 8-bit hold value. With a bit tick every third clock, hold values of 0, 3 and 6 make the release edge, the zero-hold case and a restart inside an unexpired hold window all occur within a few dozen cycles. A hold of 20 with a tick every clock checks that the counter runs a longer window without skipping or repeating a count. The station address 0x2A, with a neighbour 0x2B that differs only in the lowest bit, checks that the comparison covers the full character.

// File: rtl/rs485_link_pkg.sv
package rs485_link_pkg;

  // which modem pin carries the driver enable
  typedef enum logic {
    DIR_ON_RTS = 1'b0,
    DIR_ON_DTR = 1'b1
  } dir_pin_e;

  // level driven on the chosen pin for a given activity state
  function automatic logic dir_level(input logic active, input logic pol);
    return pol ? active : ~active;
  endfunction

  // character acceptance rule for the receive path
  function automatic logic keep_char(input logic off, input logic addr_mode,
                                     input logic ninth, input logic hit,
                                     input logic gate);
    logic keep;
    if (off)            keep = 1'b0;
    else if (!addr_mode) keep = 1'b1;
    else if (ninth)     keep = hit;
    else                keep = gate;
    return keep;
  endfunction

endpackage

// File: rtl/rs485_dir_timer.sv
module rs485_dir_timer #(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_active,
  input  logic              bit_tick,
  input  logic [HOLD_W-1:0] hold,
  output logic              active,
  output logic              release_evt
);
  logic [HOLD_W-1:0] left_q;
  logic              act_q;
  logic              left_zero;

  assign left_zero   = (left_q == '0);
  assign release_evt = act_q && !tx_active && left_zero;
  assign active      = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      left_q <= '0;
    end else if (tx_active) begin
      act_q  <= 1'b1;
      left_q <= hold;
    end else if (act_q) begin
      if (left_zero)     act_q  <= 1'b0;
      else if (bit_tick) left_q <= left_q - 1'b1;
    end
  end

  AST_ON_WITH_TX: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |=> act_q); // R4

  AST_HOLD_KEEPS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !tx_active && !left_zero) |=> act_q); // R5

  AST_COUNT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !tx_active && !left_zero && !bit_tick) |=> $stable(left_q)); // R5

  AST_OFF_ONLY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> $past(!tx_active)); // R6

endmodule

// File: rtl/rs485_pin_route.sv
module rs485_pin_route
  import rs485_link_pkg::*;
(
  input  logic auto_en,
  input  logic sel,
  input  logic pol,
  input  logic active,
  input  logic mc_rts,
  input  logic mc_dtr,
  output logic rts_o,
  output logic dtr_o
);
  dir_pin_e target;
  logic     lvl;

  assign target = dir_pin_e'(sel);
  assign lvl    = dir_level(active, pol);

  always_comb begin
    rts_o = mc_rts;
    dtr_o = mc_dtr;
    if (auto_en) begin
      unique case (target)
        DIR_ON_RTS: rts_o = lvl;
        DIR_ON_DTR: dtr_o = lvl;
      endcase
    end
  end

endmodule

// File: rtl/rs485_addr_gate.sv
module rs485_addr_gate
  import rs485_link_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              multidrop,
  input  logic              auto_addr,
  input  logic              rx_off,
  input  logic [DATA_W-1:0] match_val,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_ninth,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_is_addr,
  output logic              addr_irq,
  output logic              rx_en
);
  logic addr_mode, is_addr, hit, accept, gate_q;

  assign addr_mode = multidrop && auto_addr;
  assign is_addr   = multidrop && rx_ninth;
  assign hit       = (rx_data == match_val);
  assign accept    = rx_valid && keep_char(rx_off, addr_mode, rx_ninth, hit, gate_q);
  assign rx_en     = !rx_off && (!addr_mode || gate_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
    end else if (!addr_mode) begin
      gate_q <= 1'b0;
    end else if (rx_valid && !rx_off && rx_ninth) begin
      gate_q <= hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_is_addr <= 1'b0;
      addr_irq    <= 1'b0;
    end else begin
      out_valid   <= accept;
      out_is_addr <= accept && is_addr;
      addr_irq    <= accept && is_addr;
      if (accept) out_data <= rx_data;
    end
  end

  AST_OFF_DROPS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_off) |=> (!out_valid && !addr_irq)); // R9

  AST_IRQ_WITH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    addr_irq |-> (out_valid && out_is_addr)); // R8

  AST_MISS_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_off && addr_mode && rx_ninth && !hit) |=> (!rx_en && !out_valid)); // R11

  AST_CLOSED_DROPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && addr_mode && !rx_ninth && !rx_en) |=> !out_valid); // R10

  AST_LEAVE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_mode |=> !gate_q); // R13

endmodule

// File: rtl/rs485_link_ctrl.sv
module rs485_link_ctrl #(
  parameter int DATA_W = 8,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_auto,
  input  logic              dir_sel,
  input  logic              dir_pol,
  input  logic [HOLD_W-1:0] dir_hold,
  input  logic              mc_rts,
  input  logic              mc_dtr,
  input  logic              tx_active,
  input  logic              bit_tick,
  output logic              rts_pin,
  output logic              dtr_pin,
  input  logic              multidrop,
  input  logic              auto_addr,
  input  logic              rx_off,
  input  logic [DATA_W-1:0] station_addr,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_ninth,
  output logic              rx_out_valid,
  output logic [DATA_W-1:0] rx_out_data,
  output logic              rx_out_addr,
  output logic              addr_irq,
  output logic              rx_enabled
);
  logic dir_active;
  logic dir_release;

  rs485_dir_timer #(.HOLD_W(HOLD_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_active  (tx_active),
    .bit_tick   (bit_tick),
    .hold       (dir_hold),
    .active     (dir_active),
    .release_evt(dir_release)
  );

  rs485_pin_route u_route (
    .auto_en(dir_auto),
    .sel    (dir_sel),
    .pol    (dir_pol),
    .active (dir_active),
    .mc_rts (mc_rts),
    .mc_dtr (mc_dtr),
    .rts_o  (rts_pin),
    .dtr_o  (dtr_pin)
  );

  rs485_addr_gate #(.DATA_W(DATA_W)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .multidrop  (multidrop),
    .auto_addr  (auto_addr),
    .rx_off     (rx_off),
    .match_val  (station_addr),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_ninth   (rx_ninth),
    .out_valid  (rx_out_valid),
    .out_data   (rx_out_data),
    .out_is_addr(rx_out_addr),
    .addr_irq   (addr_irq),
    .rx_en      (rx_enabled)
  );

  AST_RELEASE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_release && !tx_active && dir_auto && !dir_sel && $stable(dir_pol)
     && $stable(dir_auto) && $stable(dir_sel))
    |=> (tx_active || rts_pin == !dir_pol)); // R5

  AST_MANUAL_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_auto |-> (rts_pin == mc_rts && dtr_pin == mc_dtr)); // R2

endmodule

// File: tb/rs485_link_ctrl_bench.sv
module rs485_link_ctrl_bench;
  localparam int DW = 8;
  localparam int HW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_auto = 0, dir_sel = 0, dir_pol = 0;
  logic [HW-1:0] dir_hold = '0;
  logic mc_rts = 1, mc_dtr = 1, tx_active = 0, bit_tick = 0;
  logic multidrop = 0, auto_addr = 0, rx_off = 0;
  logic [DW-1:0] station_addr = 8'h2A;
  logic rx_valid = 0, rx_ninth = 0;
  logic [DW-1:0] rx_data = '0;
  logic rts_pin, dtr_pin, rx_out_valid, rx_out_addr, addr_irq, rx_enabled;
  logic [DW-1:0] rx_out_data;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int tick_period = 3;
  bit tick_on = 1;

  typedef struct { logic [DW-1:0] data; logic addr; } exp_t;
  exp_t sb[$];
  bit b_gate = 0;

  // direction reference: activity and ticks still owed
  bit m_act = 0;
  int m_owed = 0;

  always #4 clk = ~clk;

  rs485_link_ctrl #(.DATA_W(DW), .HOLD_W(HW)) u_rs485_link_ctrl (
    .clk(clk), .rst_n(rst_n), .dir_auto(dir_auto), .dir_sel(dir_sel),
    .dir_pol(dir_pol), .dir_hold(dir_hold), .mc_rts(mc_rts), .mc_dtr(mc_dtr),
    .tx_active(tx_active), .bit_tick(bit_tick), .rts_pin(rts_pin), .dtr_pin(dtr_pin),
    .multidrop(multidrop), .auto_addr(auto_addr), .rx_off(rx_off),
    .station_addr(station_addr), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ninth(rx_ninth), .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data),
    .rx_out_addr(rx_out_addr), .addr_irq(addr_irq), .rx_enabled(rx_enabled)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bit tick generator
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph++;
      bit_tick = tick_on && (ph % tick_period == 0);
    end
  end

  // direction reference update and per-cycle monitor + receive scoreboard
  always @(posedge clk) begin
    if (rst_n) begin
      if (tx_active) begin
        m_act = 1; m_owed = int'(dir_hold);
      end else if (m_act) begin
        if (m_owed == 0) m_act = 0;
        else if (bit_tick) m_owed--;
      end
    end
    #2;
    if (rst_n && !done) begin
      logic lv, e_rts, e_dtr;
      lv = dir_pol ? m_act : !m_act;
      e_rts = (dir_auto && !dir_sel) ? lv : mc_rts;
      e_dtr = (dir_auto &&  dir_sel) ? lv : mc_dtr;
      check(rts_pin == e_rts && dtr_pin == e_dtr, "R5", "pins {rts,dtr}",
            {rts_pin, dtr_pin}, {e_rts, e_dtr});
      if (rx_out_valid) begin
        if (sb.size() == 0) begin
          check(0, "R9", "unexpected output (R11 discard)", rx_out_data, -1);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(rx_out_data == e.data, "R8", "data", rx_out_data, e.data);
          check(rx_out_addr == e.addr, "R7", "addr flag", rx_out_addr, e.addr);
          check(addr_irq == e.addr, "R8", "irq", addr_irq, e.addr);
        end
      end else begin
        check(!addr_irq, "R8", "irq without output", addr_irq, 0);
      end
    end
  end

  task automatic set_rx(input bit md, input bit aa, input bit off);
    multidrop = md; auto_addr = aa; rx_off = off;
    if (!(md && aa)) b_gate = 0;
    step(1);
  endtask

  // driver: compute expectation from the requirements, then drive one character
  task automatic send(input logic [DW-1:0] d, input bit ninth, input string tag);
    bit amode, take;
    amode = multidrop && auto_addr;
    if (rx_off) take = 0;
    else if (!amode) take = 1;
    else if (ninth) begin take = (d == station_addr); b_gate = take; end
    else take = b_gate;
    if (take) sb.push_back('{data: d, addr: (multidrop && ninth)});
    rx_valid = 1; rx_data = d; rx_ninth = ninth;
    @(posedge clk); #2;
    check(rx_out_valid == take, tag, "accepted", rx_out_valid, take);
    @(negedge clk);
    rx_valid = 0;
    check(rx_enabled == (!rx_off && (!amode || b_gate)), "R12", "rx_enabled",
          rx_enabled, (!rx_off && (!amode || b_gate)));
  endtask

  initial begin
    #2000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    @(posedge clk); #2;
    // R1 reset state
    check(rx_out_valid == 0 && addr_irq == 0, "R1", "outputs after reset",
          {rx_out_valid, addr_irq}, 0);
    auto_addr = 1; multidrop = 1; #1;
    check(rx_enabled == 0, "R1", "gate closed after reset", rx_enabled, 0);
    @(negedge clk);
    set_rx(0, 0, 0);

    // R2 manual pins follow modem control while transmitting
    tx_active = 1; mc_rts = 0; mc_dtr = 1; step(3);
    check(rts_pin == 0 && dtr_pin == 1, "R2", "manual pins", {rts_pin, dtr_pin}, 2'b01);
    mc_rts = 1; mc_dtr = 0; step(1);
    check(rts_pin == 1 && dtr_pin == 0, "R2", "manual pins", {rts_pin, dtr_pin}, 2'b10);
    tx_active = 0; step(5);

    // R3/R4 RTS, active-low, hold 3
    mc_rts = 1; mc_dtr = 1; dir_auto = 1; dir_sel = 0; dir_pol = 0; dir_hold = 8'd3;
    step(1);
    tx_active = 1;
    @(posedge clk); #2;
    check(rts_pin == 0 && dtr_pin == 1, "R3", "rts carries enable", {rts_pin, dtr_pin}, 2'b01);
    step(6); tx_active = 0; step(20);
    check(rts_pin == 1, "R5", "released after hold", rts_pin, 1);

    // R4 DTR, active-high, hold 0
    dir_sel = 1; dir_pol = 1; dir_hold = 8'd0; mc_rts = 0; step(1);
    check(dtr_pin == 0, "R4", "idle level high-pol", dtr_pin, 0);
    tx_active = 1;
    @(posedge clk); #2;
    check(dtr_pin == 1 && rts_pin == 0, "R4", "dtr active high", {rts_pin, dtr_pin}, 2'b01);
    step(4); tx_active = 0;
    @(posedge clk); #2;
    check(dtr_pin == 0, "R5", "zero hold releases at once", dtr_pin, 0);
    step(4);

    // R6 restart inside the hold window
    dir_sel = 0; dir_pol = 0; dir_hold = 8'd6; step(1);
    tx_active = 1; step(4); tx_active = 0; step(5);
    check(rts_pin == 0, "R6", "still held in gap", rts_pin, 0);
    tx_active = 1; step(3); tx_active = 0; step(12);
    check(rts_pin == 0, "R6", "hold reloaded", rts_pin, 0);
    step(20);
    check(rts_pin == 1, "R6", "released eventually", rts_pin, 1);

    // long hold, tick every clock
    tick_period = 1; dir_hold = 8'd20; step(1);
    tx_active = 1; step(2); tx_active = 0; step(30);
    tick_period = 3;

    // receive path
    set_rx(0, 0, 0);
    send(8'h41, 0, "R7"); send(8'h42, 1, "R7");
    set_rx(1, 0, 0);
    send(8'h05, 1, "R8"); send(8'h10, 0, "R8");
    set_rx(1, 0, 1);
    send(8'h06, 1, "R9"); send(8'h11, 0, "R9");
    set_rx(1, 1, 0);
    check(rx_enabled == 0, "R13", "auto mode starts closed", rx_enabled, 0);
    send(8'h11, 0, "R10"); send(8'h2A, 1, "R10"); send(8'h22, 0, "R10");
    send(8'h2B, 1, "R11"); send(8'h33, 0, "R11");
    send(8'h2A, 1, "R10"); send(8'h44, 0, "R10");
    set_rx(1, 1, 1);
    send(8'h2A, 1, "R9");
    set_rx(1, 1, 0);
    check(rx_enabled == 1, "R12", "gate kept while off", rx_enabled, 1);
    set_rx(1, 0, 0);
    set_rx(1, 1, 0);
    check(rx_enabled == 0, "R13", "gate closed by leaving mode", rx_enabled, 0);
    send(8'h55, 0, "R13");
    step(3);
    check(sb.size() == 0, "R10", "scoreboard drained", sb.size(), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule